// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregation Controller

The block collects sticky interrupt flags from three core sources and a parameterised set of peripheral sources, and reduces them to one CPU interrupt request. Each flag is masked by its own enable bit. The peripheral results are ORed together and pass through a group enable. The core results and the gated peripheral result then meet a global enable. The request output is registered.

A second output, the wake-up line, is formed from the individually enabled flags before either the group gate or the global gate. A sleeping core therefore resumes even when interrupts are globally off. In that case it continues without branching to the vector.

Software reaches the block through a small register port. The port has four addresses: a core control/status byte, the peripheral flag word, the peripheral enable word, and a write-one-to-clear view of the peripheral flags. The sources signal events on one-cycle set pulses.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all three readable registers (addresses 0, 1 and 2) read zero, and both `irq_o` and `wake_o` are low.
- R2: Address 0 is the core byte, and its fields are laid out as follows:
  - bit 7: global enable
  - bit 6: peripheral-group enable
  - bit 5: timer-overflow enable
  - bit 4: external-pin enable
  - bit 3: port-change enable
  - bit 2: timer-overflow flag
  - bit 1: external-pin flag
  - bit 0: port-change flag

  A write to address 0 loads all eight bits, and a read returns them in the upper bits' absence zero-filled.
- R3: A set pulse sets its flag at the next clock edge. `core_set_i` bit 0 sets the port-change flag, bit 1 the external-pin flag and bit 2 the timer-overflow flag; `periph_set_i` bit k sets peripheral flag k. A flag stays set until software writes it.
- R4: When a set pulse and a software write or clear of the same flag fall in the same cycle, the flag ends up set.
- R5: When the global enable is set and a core flag is set together with its enable, `irq_o` goes high one cycle after the flag register holds that state.
- R6: An enabled peripheral flag raises `irq_o` only while both the peripheral-group enable and the global enable are set.
- R7: With the global enable clear, `irq_o` stays low whatever flags and enables are set.
- R8: `wake_o` is high in the same cycle that any flag is set together with its own enable, irrespective of the group and global enables. It is low when no set flag has its enable set.
- R9: `PERIPH_PRESENT` bit k marks peripheral k as present, and the default value marks source 0 as absent. For an absent source, both the flag and the enable read as zero, and neither a set pulse nor a write changes them.
- R10: A write to address 3 clears exactly those peripheral flags whose data bits are one, and leaves the others as they were.
- R11: `irq_o` falls one cycle after the qualifying flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 core byte, 1 peripheral flags, 2 peripheral enables, 3 flag clear |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| core_set_i | input | 3 | Set pulses: port-change, external-pin, timer-overflow |
| periph_set_i | input | 9 | Set pulses for the peripheral sources |
| irq_o | output | 1 | Registered CPU interrupt request |
| wake_o | output | 1 | Wake-up request from sleep |

## Verification
The collision that matters is a hardware set pulse arriving in the same cycle as a software write to the flag's register. This covers two cases: a full write to address 0 or 1 that would leave the flag at zero, and a write-one-to-clear at address 3. The bench drives the pulse and the write strobe together in one cycle. It then reads the register back in the next cycle and expects the flag to be set. It also expects `irq_o` to follow one cycle later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned N_CORE   = 3;
  localparam int unsigned N_PERIPH = 9;
  localparam int unsigned N_CTL    = 5;

  typedef enum logic [1:0] {
    ADDR_CORE  = 2'd0,
    ADDR_PFLAG = 2'd1,
    ADDR_PEN   = 2'd2,
    ADDR_PCLR  = 2'd3
  } reg_addr_e;

  // Core control bits inside the enable bank (bits 7:3 of the core byte)
  localparam int unsigned CTL_GIE  = 4;
  localparam int unsigned CTL_PEIE = 3;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] PRESENT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (PRESENT[i]) begin : g_on
      logic q, d;
      always_comb begin
        d = q;
        if (wr_i)      d = wdata_i[i];
        else if (clr_i && clr_mask_i[i]) d = 1'b0;
        if (set_i[i])  d = 1'b1; // hardware set wins
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d;
      end
      assign flags_o[i] = q;
    end else begin : g_off
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] PRESENT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (PRESENT[i]) begin : g_on
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b0;
        else if (wr_i) q <= wdata_i[i];
      end
      assign en_o[i] = q;
    end else begin : g_off
      assign en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned NC = 3,
  parameter int unsigned NP = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] core_flags_i,
  input  logic [NC-1:0] core_en_i,
  input  logic [NP-1:0] per_flags_i,
  input  logic [NP-1:0] per_en_i,
  input  logic          gie_i,
  input  logic          peie_i,
  output logic          wake_o,
  output logic          irq_o
);
  logic core_act, per_act, irq_d, irq_q;

  assign core_act = |(core_flags_i & core_en_i);
  assign per_act  = |(per_flags_i & per_en_i);
  // wake taken ahead of both group and global gates
  assign wake_o   = core_act | per_act;
  assign irq_d    = gie_i & (core_act | (peie_i & per_act));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter logic [N_PERIPH-1:0] PERIPH_PRESENT = 9'h1FE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [N_CORE-1:0]   core_set_i,
  input  logic [N_PERIPH-1:0] periph_set_i,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int unsigned CORE_W = N_CORE + N_CTL;

  logic [N_CORE-1:0]   core_flags;
  logic [N_CTL-1:0]    ctl_q;
  logic [N_CORE-1:0]   core_en;
  logic [N_PERIPH-1:0] per_flags, per_en;
  logic                gie, peie;
  logic                wr_core, wr_pflag, wr_pen, wr_pclr;

  assign wr_core  = reg_we_i && (reg_addr_i == ADDR_CORE);
  assign wr_pflag = reg_we_i && (reg_addr_i == ADDR_PFLAG);
  assign wr_pen   = reg_we_i && (reg_addr_i == ADDR_PEN);
  assign wr_pclr  = reg_we_i && (reg_addr_i == ADDR_PCLR);

  irq_flag_bank #(.N(N_CORE), .PRESENT('1)) u_core_flags (
    .clk_i, .rst_ni,
    .set_i      (core_set_i),
    .wr_i       (wr_core),
    .wdata_i    (reg_wdata_i[N_CORE-1:0]),
    .clr_i      (1'b0),
    .clr_mask_i ('0),
    .flags_o    (core_flags)
  );

  irq_en_bank #(.N(N_CTL), .PRESENT('1)) u_core_ctl (
    .clk_i, .rst_ni,
    .wr_i    (wr_core),
    .wdata_i (reg_wdata_i[CORE_W-1:N_CORE]),
    .en_o    (ctl_q)
  );

  assign core_en = ctl_q[N_CORE-1:0];
  assign gie     = ctl_q[CTL_GIE];
  assign peie    = ctl_q[CTL_PEIE];

  irq_flag_bank #(.N(N_PERIPH), .PRESENT(PERIPH_PRESENT)) u_per_flags (
    .clk_i, .rst_ni,
    .set_i      (periph_set_i),
    .wr_i       (wr_pflag),
    .wdata_i    (reg_wdata_i[N_PERIPH-1:0]),
    .clr_i      (wr_pclr),
    .clr_mask_i (reg_wdata_i[N_PERIPH-1:0]),
    .flags_o    (per_flags)
  );

  irq_en_bank #(.N(N_PERIPH), .PRESENT(PERIPH_PRESENT)) u_per_en (
    .clk_i, .rst_ni,
    .wr_i    (wr_pen),
    .wdata_i (reg_wdata_i[N_PERIPH-1:0]),
    .en_o    (per_en)
  );

  irq_combine #(.NC(N_CORE), .NP(N_PERIPH)) u_combine (
    .clk_i, .rst_ni,
    .core_flags_i (core_flags),
    .core_en_i    (core_en),
    .per_flags_i  (per_flags),
    .per_en_i     (per_en),
    .gie_i        (gie),
    .peie_i       (peie),
    .wake_o       (wake_o),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CORE:  reg_rdata_o[CORE_W-1:0]   = {ctl_q, core_flags};
      ADDR_PFLAG: reg_rdata_o[N_PERIPH-1:0] = per_flags;
      ADDR_PEN:   reg_rdata_o[N_PERIPH-1:0] = per_en;
      default:    reg_rdata_o[N_PERIPH-1:0] = per_flags;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned NC = 3,
  parameter int unsigned NP = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [NC-1:0] core_set_i,
  input logic [NP-1:0] periph_set_i,
  input logic [NP-1:0] present_i,
  input logic [NC-1:0] core_flags,
  input logic [NC-1:0] core_en,
  input logic [NP-1:0] per_flags,
  input logic          gie,
  input logic          peie,
  input logic          irq_o,
  input logic          wake_o
);
  assert_set_wins_core_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|core_set_i) |=> ((core_flags & $past(core_set_i)) == $past(core_set_i)));

  assert_set_wins_per_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(periph_set_i & present_i)) |=>
      ((per_flags & $past(periph_set_i & present_i)) == $past(periph_set_i & present_i)));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (((core_flags & $past(core_flags)) == $past(core_flags)) &&
                   ((per_flags & $past(per_flags)) == $past(per_flags))));

  assert_absent_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(periph_set_i & ~present_i)) |=> ((per_flags & ~present_i) == '0));

  assert_global_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie |=> !irq_o);

  assert_core_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie && |(core_flags & core_en)) |=> irq_o);

  assert_group_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!peie && !(|(core_flags & core_en))) |=> !irq_o);

  assert_irq_implies_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wake_o));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NC(irq_pkg::N_CORE), .NP(irq_pkg::N_PERIPH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .core_set_i   (core_set_i),
  .periph_set_i (periph_set_i),
  .present_i    (PERIPH_PRESENT),
  .core_flags   (core_flags),
  .core_en      (core_en),
  .per_flags    (per_flags),
  .gie          (gie),
  .peie         (peie),
  .irq_o        (irq_o),
  .wake_o       (wake_o)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [2:0]  core_set_i = '0;
  logic [8:0]  periph_set_i = '0;
  logic        irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          kind; // 0 irq, 1 wake, 2 rdata
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  irq_aggregator dut (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .core_set_i, .periph_set_i, .irq_o, .wake_o
  );

  always #4 clk_i = ~clk_i; // 125 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compares queued expectations in mid-cycle
  initial begin
    forever begin
      @(negedge clk_i);
      for (int i = 0; i < sb.size();) begin
        if (sb[i].due == cyc) begin
          logic [15:0] act;
          case (sb[i].kind)
            0:       act = {15'd0, irq_o};
            1:       act = {15'd0, wake_o};
            default: act = reg_rdata_o;
          endcase
          checks++;
          if (act !== sb[i].exp) begin
            errors++;
            $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                     sb[i].req, sb[i].kind, cyc, act, sb[i].exp);
          end
          sb.delete(i);
        end else i++;
      end
    end
  end

  task automatic tick();
    @(posedge clk_i); #2;
    reg_we_i = 1'b0; core_set_i = '0; periph_set_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    tick();
    reg_addr_i = a; reg_we_i = 1'b1; reg_wdata_i = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string r);
    tick();
    reg_addr_i = a;
    sb.push_back('{cyc, 2, e, r});
  endtask

  task automatic exp_irq(input int dly, input logic v, input string r);
    sb.push_back('{cyc + dly, 0, {15'd0, v}, r});
  endtask

  task automatic exp_wake(input int dly, input logic v, input string r);
    sb.push_back('{cyc + dly, 1, {15'd0, v}, r});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1 reset state
    rd(0, 16'h0000, "R1"); exp_irq(0, 0, "R1"); exp_wake(0, 0, "R1");
    rd(1, 16'h0000, "R1");
    rd(2, 16'h0000, "R1");
    // R2 layout: ext-pin and port-change enables
    wr(0, 16'h0018);
    rd(0, 16'h0018, "R2"); exp_wake(0, 0, "R8");
    // R3/R8/R7: ext-pin pulse with global enable off
    tick(); core_set_i = 3'b010;
    rd(0, 16'h001A, "R3"); exp_wake(0, 1, "R8"); exp_irq(1, 0, "R7");
    tick(); tick();
    rd(0, 16'h001A, "R3");
    // R5/R11: turn on global enable
    wr(0, 16'h009A);
    rd(0, 16'h009A, "R2"); exp_irq(0, 0, "R11"); exp_irq(1, 1, "R5");
    tick();
    wr(0, 16'h0098); exp_irq(0, 1, "R11");
    rd(0, 16'h0098, "R3"); exp_wake(0, 0, "R8"); exp_irq(0, 1, "R11"); exp_irq(1, 0, "R11");
    // R4: port-change pulse collides with a write that clears it
    wr(0, 16'h0098); core_set_i = 3'b001;
    rd(0, 16'h0099, "R4"); exp_irq(1, 1, "R5");
    wr(0, 16'h0000);
    rd(0, 16'h0000, "R2");
    // R6: peripheral path behind group enable
    wr(2, 16'h0004);
    wr(0, 16'h0080);
    tick(); periph_set_i = 9'h004;
    rd(1, 16'h0004, "R3"); exp_wake(0, 1, "R8"); exp_irq(1, 0, "R6");
    wr(0, 16'h00C0);
    tick(); exp_irq(1, 1, "R6");
    // R10: write-one-to-clear
    tick(); periph_set_i = 9'h008;
    rd(1, 16'h000C, "R3");
    wr(3, 16'h0004);
    rd(1, 16'h0008, "R10"); exp_wake(0, 0, "R8"); exp_irq(1, 0, "R10");
    // R4 on peripheral flags: clear and write collisions
    wr(3, 16'h0020); periph_set_i = 9'h020;
    rd(1, 16'h0028, "R4");
    wr(1, 16'h0000); periph_set_i = 9'h040;
    rd(1, 16'h0040, "R4");
    // R9: absent source 0
    wr(2, 16'h01FF);
    rd(2, 16'h01FE, "R9");
    wr(1, 16'h01FF);
    rd(1, 16'h01FE, "R9");
    wr(1, 16'h0000);
    tick(); periph_set_i = 9'h001;
    rd(1, 16'h0000, "R9"); exp_wake(0, 0, "R9");
    wr(0, 16'h0000);
    repeat (4) tick();
    while (sb.size() != 0) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule